// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM. The host hands it one word per request over a valid/ready handshake, either a read or a write. The controller then produces the chip-select, output-enable, write-enable, address and write-data signals that the RAM needs. Every phase of those signals is sized from the RAM's nanosecond timing figures, which are turned into whole system-clock cycles at elaboration.

A read holds chip select and output enable low for the longer of the read cycle time and the slowest data-valid path. The data bus is captured at the end of the access time and returned with a one-cycle response pulse. A write keeps output enable high and waits out the address setup time. It then pulls write enable low for long enough to meet the pulse-width, chip-select-to-end and address-to-end limits. Write enable is released before chip select, so the write ends under write-enable control. Each access takes its full cycle count and is followed by one idle cycle before the next request can be taken.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and directly after a synchronous active-high reset, `sram_cs_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` and `resp_valid` are 0, and `req_ready` is 1.
- R2: Each nanosecond parameter becomes a cycle count equal to ceil(ns / `CLK_NS`), with 0 kept as 0. The write-enable low time is WL = max(write pulse, chip-select-to-end minus setup, address-to-end minus setup, 1) cycles, and write enable is never low for fewer cycles than that.
- R3: A read accepted on clock edge E0 shows `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 from E0 for RDC = max(read cycle, RDW) cycles. RDW = max(address access, chip-select access, output-enable access, 1).
- R4: Read data is captured on edge E0+RDW. `resp_valid` is 1 for exactly the one cycle after that edge, and `resp_rdata` then holds the captured word.
- R5: A write accepted on edge E0 keeps `sram_oe_n`=1 throughout. `sram_we_n` stays 1 for AS (setup) cycles and then 0 for WL cycles.
- R6: `sram_dq_oe` is 1, and `sram_dq_out` carries the request's write data, from the first cycle with write enable low through the one cycle after write enable rises. At all other times `sram_dq_oe` is 0.
- R7: A write lasts WRC = AS + WL + max(1, write cycle − AS − WL) cycles. Chip select stays low for at least one cycle after write enable rises.
- R8: `req_ready` is 0 from the acceptance edge until the access's cycle count has elapsed. Request inputs that change while busy have no effect on the access in progress.
- R9: `sram_addr` equals the accepted request's address and stays stable for as long as `sram_cs_n` is 0.
- R10: When a write completes, `resp_valid` pulses for one cycle, in the cycle after edge E0+WRC, together with `req_ready` returning to 1.
- R11: `sram_oe_n` and `sram_we_n` are never 0 together, and neither is 0 while `sram_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Captured read word |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_addr | output | ADDR_W | RAM address |
| sram_dq_out | output | DATA_W | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | DATA_W | Data from the RAM |

## Verification
The bench counts cycles from the acceptance edge and samples every pin on the falling edge of each cycle. It expects read pins for RDC cycles, a write-enable window starting at cycle AS and lasting WL cycles, data drive up to cycle AS+WL, a read response at cycle RDW and a write response at cycle WRC. The RAM model in the bench returns the inverted word until chip select and output enable have been low for the computed access count, so a capture one cycle early is seen as wrong data. Every address of a small configuration is written and read back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD   = 3'd1,
    PH_WSET = 3'd2,
    PH_WPUL = 3'd3,
    PH_WREC = 3'd4
  } phase_e;

  // Nanoseconds to whole clock cycles, rounding up; zero stays zero.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    if (ns <= 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 6,
  parameter int AS_CYC  = 0,
  parameter int WL_CYC  = 5,
  parameter int REC_CYC = 1,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WL_LOAD  = CNT_W'(WL_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);

  logic [CNT_W-1:0] cnt_d;
  phase_e           wr_entry;
  logic [CNT_W-1:0] wr_load;
  logic             last;

  // The setup phase exists only when the address setup count is nonzero.
  generate
    if (AS_CYC > 0) begin : g_setup
      assign wr_entry = PH_WSET;
      assign wr_load  = CNT_W'(AS_CYC - 1);
    end else begin : g_nosetup
      assign wr_entry = PH_WPUL;
      assign wr_load  = WL_LOAD;
    end
  endgenerate

  assign last = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q - 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = cnt_q;
        if (start) begin
          if (start_wr) begin
            phase_d = wr_entry;
            cnt_d   = wr_load;
          end else begin
            phase_d = PH_RD;
            cnt_d   = RD_LOAD;
          end
        end
      end
      PH_RD: begin
        if (last) phase_d = PH_IDLE;
      end
      PH_WSET: begin
        if (last) begin
          phase_d = PH_WPUL;
          cnt_d   = WL_LOAD;
        end
      end
      PH_WPUL: begin
        if (last) begin
          phase_d = PH_WREC;
          cnt_d   = REC_LOAD;
        end
      end
      PH_WREC: begin
        if (last) phase_d = PH_IDLE;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  phase_e            phase_q,
  input  phase_e            phase_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic hold_cycle;

  // Data stays on the bus for the one cycle after write enable rises.
  assign hold_cycle = (phase_q == PH_WPUL) && (phase_d == PH_WREC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b1;
      cs_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ready <= (phase_d == PH_IDLE);
      cs_n  <= (phase_d == PH_IDLE);
      oe_n  <= (phase_d != PH_RD);
      we_n  <= (phase_d != PH_WPUL);
      dq_oe <= (phase_d == PH_WPUL) || hold_cycle;
    end
  end

  // Address and write data registers carry no reset.
  always_ff @(posedge clk) begin
    if (start) begin
      addr   <= req_addr;
      dq_out <= req_wdata;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
  import sram_ctrl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 3,
  parameter int SAMPLE_AT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [DATA_W-1:0] dq_in,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata
);

  logic rd_take;
  logic wr_done;

  assign rd_take = (phase_q == PH_RD)   && (cnt_q == CNT_W'(SAMPLE_AT));
  assign wr_done = (phase_q == PH_WREC) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) resp_valid <= 1'b0;
    else     resp_valid <= rd_take || wr_done;
  end

  always_ff @(posedge clk) begin
    if (rd_take) resp_rdata <= dq_in;
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_CO_NS = 55,
  parameter int T_OE_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_AS_NS = 0,
  parameter int T_WP_NS = 40,
  parameter int T_CW_NS = 45,
  parameter int T_AW_NS = 45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              sram_cs_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int RC_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int AA_CYC  = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int CO_CYC  = ns_to_cyc(T_CO_NS, CLK_NS);
  localparam int OE_CYC  = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int AS_CYC  = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int WP_CYC  = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int CW_CYC  = ns_to_cyc(T_CW_NS, CLK_NS);
  localparam int AW_CYC  = ns_to_cyc(T_AW_NS, CLK_NS);

  localparam int RD_WAIT = imax(imax(imax(AA_CYC, CO_CYC), OE_CYC), 1);
  localparam int RD_CYC  = imax(RC_CYC, RD_WAIT);
  localparam int WL_CYC  = imax(imax(imax(WP_CYC, CW_CYC - AS_CYC), AW_CYC - AS_CYC), 1);
  localparam int REC_CYC = imax(1, WC_CYC - AS_CYC - WL_CYC);
  localparam int MAX_CYC = imax(imax(RD_CYC, AS_CYC), imax(WL_CYC, REC_CYC));
  localparam int CNT_W   = imax(1, $clog2(MAX_CYC + 1));

  phase_e           phase_q;
  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign start = req_valid && req_ready;

  sram_phase_seq #(
    .RD_CYC (RD_CYC),
    .AS_CYC (AS_CYC),
    .WL_CYC (WL_CYC),
    .REC_CYC(REC_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .start_wr(req_write),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .cnt_q   (cnt_q)
  );

  sram_pin_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .ready    (req_ready),
    .cs_n     (sram_cs_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .addr     (sram_addr),
    .dq_out   (sram_dq_out),
    .dq_oe    (sram_dq_oe)
  );

  sram_rd_capture #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .SAMPLE_AT(RD_CYC - RD_WAIT)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .phase_q   (phase_q),
    .cnt_q     (cnt_q),
    .dq_in     (sram_dq_in),
    .resp_valid(resp_valid),
    .resp_rdata(resp_rdata)
  );

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CLK_NS  = 10,
  parameter int T_AS_NS = 0,
  parameter int T_WP_NS = 40,
  parameter int T_CW_NS = 45,
  parameter int T_AW_NS = 45
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic              ready,
  input logic              resp_valid,
  input logic [ADDR_W-1:0] addr
);

  localparam int AS_C = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int WL_C = imax(imax(imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                       ns_to_cyc(T_CW_NS, CLK_NS) - AS_C),
                                  ns_to_cyc(T_AW_NS, CLK_NS) - AS_C), 1);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (rst)        we_low_cnt <= '0;
    else if (!we_n) we_low_cnt <= we_low_cnt + 16'd1;
    else            we_low_cnt <= '0;
  end

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (we_low_cnt >= 16'(WL_C)));                         // R2
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);                                        // R4
  AST_DATA_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> dq_oe);                                                   // R6
  AST_WE_BEFORE_CS: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $past(we_n));                                       // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !ready);                                                  // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> $stable(addr));                         // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    (oe_n || we_n));                                                    // R11
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    (!oe_n || !we_n) |-> !cs_n);                                        // R11

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .CLK_NS (CLK_NS),
  .T_AS_NS(T_AS_NS),
  .T_WP_NS(T_WP_NS),
  .T_CW_NS(T_CW_NS),
  .T_AW_NS(T_AW_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (sram_cs_n),
  .oe_n      (sram_oe_n),
  .we_n      (sram_we_n),
  .dq_oe     (sram_dq_oe),
  .ready     (req_ready),
  .resp_valid(resp_valid),
  .addr      (sram_addr)
);

// File: tb/sram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_test;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int CLKP = 10;
  localparam int NRC = 55, NAA = 55, NCO = 55, NOE = 25;
  localparam int NWC = 55, NAS = 5, NWP = 40, NCW = 45, NAW = 45;

  function automatic int cy(input int ns);
    return (ns <= 0) ? 0 : (ns + CLKP - 1) / CLKP;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R2: cycle counts derived from the nanosecond figures
  localparam int AS  = cy(NAS);
  localparam int WL  = mx(mx(mx(cy(NWP), cy(NCW) - AS), cy(NAW) - AS), 1);
  localparam int WRC = AS + WL + mx(1, cy(NWC) - AS - WL);
  localparam int RDW = mx(mx(mx(cy(NAA), cy(NCO)), cy(NOE)), 1);
  localparam int RDC = mx(cy(NRC), RDW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] resp_rdata, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic [DW-1:0] ram    [0:(1<<AW)-1];
  int cs_cnt = 0, oe_cnt = 0, we_cnt = 0;
  logic [DW-1:0] wr_lat;

  always #(CLKP/2) clk = ~clk;

  sram_cycle_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKP),
    .T_RC_NS(NRC), .T_AA_NS(NAA), .T_CO_NS(NCO), .T_OE_NS(NOE),
    .T_WC_NS(NWC), .T_AS_NS(NAS), .T_WP_NS(NWP), .T_CW_NS(NCW), .T_AW_NS(NAW)
  ) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // RAM model: data turns valid only after the access counts have elapsed.
  assign sram_dq_in = (!sram_cs_n && !sram_oe_n && sram_we_n &&
                       (cs_cnt + 1 >= mx(cy(NAA), cy(NCO))) && (oe_cnt + 1 >= cy(NOE)))
                      ? ram[sram_addr] : ~ram[sram_addr];

  always @(posedge clk) begin
    if (rst) begin
      cs_cnt <= 0; oe_cnt <= 0; we_cnt <= 0;
    end else begin
      cs_cnt <= sram_cs_n ? 0 : cs_cnt + 1;
      oe_cnt <= sram_oe_n ? 0 : oe_cnt + 1;
      if (!sram_we_n) begin
        we_cnt <= we_cnt + 1;
        wr_lat <= sram_dq_out;
      end else if (we_cnt != 0) begin
        // first cycle after write enable rose
        chk(we_cnt >= WL, "R2 we low width", we_cnt, WL);
        chk(!sram_cs_n, "R7 cs low after we rise", sram_cs_n, 0);
        ram[sram_addr] <= wr_lat;
        we_cnt <= 0;
      end
    end
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    n = wr ? WRC : RDC;
    for (int j = 0; j <= n; j++) begin
      @(negedge clk);
      chk((sram_oe_n || sram_we_n) && ((sram_oe_n && sram_we_n) || !sram_cs_n),
          "R11 strobe rules", {sram_cs_n, sram_oe_n, sram_we_n}, 0);
      if (j < n) begin
        chk(!req_ready, "R8 busy not ready", req_ready, 0);
        chk(sram_addr == a, "R9 address held", sram_addr, a);
        if (wr) begin
          chk(sram_oe_n == 1'b1, "R5 oe high in write", sram_oe_n, 1);
          chk(sram_we_n == !(j >= AS && j < AS + WL), "R5 we window", sram_we_n,
              !(j >= AS && j < AS + WL));
          chk(sram_dq_oe == (j >= AS && j <= AS + WL), "R6 data drive", sram_dq_oe,
              (j >= AS && j <= AS + WL));
          if (j >= AS && j <= AS + WL)
            chk(sram_dq_out == d, "R6 write data", sram_dq_out, d);
          chk(!sram_cs_n, "R7 cs low in write", sram_cs_n, 0);
          chk(!resp_valid, "R10 no early response", resp_valid, 0);
        end else begin
          chk({sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe} == 4'b0010,
              "R3 read pins", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b0010);
        end
      end else begin
        chk({sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready} == 5'b11101,
            "R8 released after cycle", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready},
            5'b11101);
        if (wr) chk(resp_valid, "R10 write response", resp_valid, 1);
      end
      if (!wr) begin
        chk(resp_valid == (j == RDW), "R4 response timing", resp_valid, (j == RDW));
        if (j == RDW) chk(resp_rdata == shadow[a], "R4 read data", resp_rdata, shadow[a]);
      end
      // change the request inputs while busy: must be ignored (R8)
      if (j == 0) begin req_addr = ~a; req_write = ~wr; req_wdata = ~d; end
      if (j == n - 1) req_valid = 1'b0;
    end
    if (wr) shadow[a] = d;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin ram[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk({sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, resp_valid} == 5'b11100,
        "R1 pins in reset", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, resp_valid}, 5'b11100);
    rst = 1'b0;
    @(negedge clk);
    chk({sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, resp_valid, req_ready} == 6'b111001,
        "R1 state after reset",
        {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe, resp_valid, req_ready}, 6'b111001);
    for (int a = 0; a < (1 << AW); a++) access(1'b1, AW'(a), DW'(a * 37 + 11));
    for (int a = 0; a < (1 << AW); a++) access(1'b0, AW'(a), '0);
    access(1'b1, '0, 8'hFF);
    access(1'b1, '1, 8'h00);
    access(1'b0, '1, '0);
    access(1'b0, '0, '0);
    for (int a = (1 << AW) - 1; a >= 0; a -= 5) begin
      access(1'b1, AW'(a), DW'(~(a * 3)));
      access(1'b0, AW'(a), '0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule